// File: doc/BRIEF.md
# DDR Region Security Address Filter

This block decides, for every memory access, whether the access may proceed given its security attribute. Software programs eight address windows in units of one megabyte. Each window can be marked as secure-only. A ninth setting protects all memory that lies outside every window, and a global bypass opens the whole space to everyone.

Configuration arrives on a simple write port as 17 half-word registers. Each 32-bit write carries a per-bit write mask in its upper half. The access side takes an address, a secure flag and a valid strobe. A registered allow/deny verdict appears one clock later.

Top module: `ddrsec_filter`

## Requirements
- R1: After synchronous reset, every register is zero, `dec_valid` is 0 and `dec_allow` is 1. With that state every access is allowed.
- R2: A write carries data in `cfg_wdata[15:0]` and per-bit enables in `cfg_wdata[31:16]`. A data bit whose enable is 0 keeps its previous value, and registers not addressed are unchanged.
- R3: Register n (0..7) holds the start megabyte of window n, and register n+8 holds its end megabyte. An address is inside window n when `acc_addr >> 20` lies between start and end, with both bounds included.
- R4: A window with start 0 and end 0 covers exactly addresses 0x0 to 0xFFFFF.
- R5: Register 16 bits [7:0] enable windows 0..7 as secure-only. A non-secure access inside any enabled window is denied. A window whose bit is 0 denies nothing.
- R6: A secure access (`acc_secure`=1) is always allowed.
- R7: Register 16 bit 8 protects the remaining memory. When it is set, a non-secure access that lies inside no window is denied, whether or not that window is enabled. An access inside a disabled window stays allowed.
- R8: Register 16 bit 9 is a global bypass. While it is 1, every access is allowed.
- R9: The verdict is registered. `dec_valid` equals `acc_valid` from the previous cycle, and `dec_allow` reflects the access presented in that cycle.
- R10: Writes with `cfg_idx` of 17 or more change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 5 | Register index (0..16 valid) |
| cfg_wdata | input | 32 | Write mask [31:16], data [15:0] |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access byte address |
| acc_secure | input | 1 | Access is secure |
| dec_valid | output | 1 | Verdict valid, one cycle after the access |
| dec_allow | output | 1 | 1 = allow, 0 = deny |

## Verification
Directed accesses probe the window edges: one megabyte below the start, at the start, at the last byte of the end megabyte, and one megabyte past the end. These show whether the end bound is treated as inclusive or exclusive. Separate directed cases cover the zero-sized first-megabyte window, a disabled window under default protection, and bypass. These separate the three policy levels from one another. Random register writes with random masks, mixed with random secure and non-secure addresses in the low 64 MB, check the masking and the verdict against a bench model. Random full-range addresses exercise the default region.

// File: rtl/ddrsec_pkg.sv
package ddrsec_pkg;
  parameter int DEF_NUM_WIN  = 8;
  parameter int DEF_REG_W    = 16;
  parameter int DEF_ADDR_W   = 32;
  parameter int DEF_MB_SHIFT = 20;

  function automatic int regs_for(input int n_win);
    return 2 * n_win + 1;
  endfunction
endpackage

// File: rtl/ddrsec_cfg_regs.sv
module ddrsec_cfg_regs #(
  parameter int NUM_WIN  = ddrsec_pkg::DEF_NUM_WIN,
  parameter int REG_W    = ddrsec_pkg::DEF_REG_W,
  localparam int NUM_REGS = ddrsec_pkg::regs_for(NUM_WIN),
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [IDX_W-1:0]                idx,
  input  logic [2*REG_W-1:0]              wdata,
  output logic [NUM_WIN-1:0][REG_W-1:0]   win_lo,
  output logic [NUM_WIN-1:0][REG_W-1:0]   win_hi,
  output logic [NUM_WIN-1:0]              win_en,
  output logic                            dflt_sec,
  output logic                            bypass
);
  localparam int CTRL = 2 * NUM_WIN;

  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
  logic [REG_W-1:0] wmask, wval;

  assign wmask = wdata[2*REG_W-1:REG_W];
  assign wval  = wdata[REG_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_q[i] <= '0;
      else if (we && idx == IDX_W'(i))
        regs_q[i] <= (regs_q[i] & ~wmask) | (wval & wmask);
    end

    // R2 / R10: unaddressed registers hold
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      !(we && idx == IDX_W'(i)) |=> $stable(regs_q[i]));
    // R2: unmasked bits hold
    a_r2_masked: assert property (@(posedge clk) disable iff (rst)
      (we && idx == IDX_W'(i)) |=>
        (((regs_q[i] ^ $past(regs_q[i])) & ~$past(wmask)) == '0));
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_out
    assign win_lo[w] = regs_q[w];
    assign win_hi[w] = regs_q[w + NUM_WIN];
  end

  assign win_en   = regs_q[CTRL][NUM_WIN-1:0];
  assign dflt_sec = regs_q[CTRL][NUM_WIN];
  assign bypass   = regs_q[CTRL][NUM_WIN+1];
endmodule

// File: rtl/ddrsec_win_match.sv
module ddrsec_win_match #(
  parameter int NUM_WIN  = ddrsec_pkg::DEF_NUM_WIN,
  parameter int REG_W    = ddrsec_pkg::DEF_REG_W,
  parameter int ADDR_W   = ddrsec_pkg::DEF_ADDR_W,
  parameter int MB_SHIFT = ddrsec_pkg::DEF_MB_SHIFT,
  localparam int MB_W    = ADDR_W - MB_SHIFT
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_WIN-1:0][REG_W-1:0]  win_lo,
  input  logic [NUM_WIN-1:0][REG_W-1:0]  win_hi,
  output logic [NUM_WIN-1:0]             hit
);
  logic [MB_W-1:0]  mb_raw;
  logic [REG_W-1:0] mb;

  assign mb_raw = addr[ADDR_W-1:MB_SHIFT];
  assign mb     = REG_W'(mb_raw);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hit[w] = (mb >= win_lo[w]) && (mb <= win_hi[w]);
  end
endmodule

// File: rtl/ddrsec_policy.sv
module ddrsec_policy #(
  parameter int NUM_WIN = ddrsec_pkg::DEF_NUM_WIN
) (
  input  logic [NUM_WIN-1:0] hit,
  input  logic [NUM_WIN-1:0] win_en,
  input  logic               dflt_sec,
  input  logic               bypass,
  input  logic               secure,
  output logic               allow
);
  logic in_guarded_win, in_any_win, guarded;

  always_comb begin
    in_guarded_win = |(hit & win_en);
    in_any_win     = |hit;
    guarded        = in_guarded_win || (!in_any_win && dflt_sec);
    allow          = bypass || secure || !guarded;
  end
endmodule

// File: rtl/ddrsec_filter.sv
module ddrsec_filter #(
  parameter int NUM_WIN  = ddrsec_pkg::DEF_NUM_WIN,
  parameter int REG_W    = ddrsec_pkg::DEF_REG_W,
  parameter int ADDR_W   = ddrsec_pkg::DEF_ADDR_W,
  parameter int MB_SHIFT = ddrsec_pkg::DEF_MB_SHIFT,
  localparam int IDX_W   = $clog2(ddrsec_pkg::regs_for(NUM_WIN))
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [2*REG_W-1:0] cfg_wdata,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_secure,
  output logic               dec_valid,
  output logic               dec_allow
);
  logic [NUM_WIN-1:0][REG_W-1:0] win_lo, win_hi;
  logic [NUM_WIN-1:0]            win_en, hit;
  logic                          dflt_sec, bypass, allow_c;

  ddrsec_cfg_regs #(.NUM_WIN(NUM_WIN), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .win_lo(win_lo), .win_hi(win_hi), .win_en(win_en),
    .dflt_sec(dflt_sec), .bypass(bypass)
  );

  ddrsec_win_match #(.NUM_WIN(NUM_WIN), .REG_W(REG_W), .ADDR_W(ADDR_W),
                     .MB_SHIFT(MB_SHIFT)) u_match (
    .addr(acc_addr), .win_lo(win_lo), .win_hi(win_hi), .hit(hit)
  );

  ddrsec_policy #(.NUM_WIN(NUM_WIN)) u_policy (
    .hit(hit), .win_en(win_en), .dflt_sec(dflt_sec), .bypass(bypass),
    .secure(acc_secure), .allow(allow_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_allow <= 1'b1;
    end else begin
      dec_valid <= acc_valid;
      if (acc_valid) dec_allow <= allow_c;
    end
  end

  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> dec_valid);
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !dec_valid);
  a_r6_secure_pass: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_secure) |=> dec_allow);
  a_r8_bypass_pass: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && bypass) |=> dec_allow);
  a_r5_guarded_deny: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_secure && !bypass && |(hit & win_en)) |=> !dec_allow);
endmodule

// File: tb/ddrsec_filter_tb_top.sv
`timescale 1ns/1ps
module ddrsec_filter_tb_top;
  localparam int NW = 8;
  localparam int NR = 2 * NW + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_secure = 1'b0;
  logic        dec_valid, dec_allow;

  int errors = 0;
  int checks = 0;
  logic [15:0] mreg [NR];

  always #10 clk = ~clk;

  ddrsec_filter dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_secure(acc_secure), .dec_valid(dec_valid), .dec_allow(dec_allow)
  );

  function automatic logic expect_allow(input logic [31:0] a, input logic s);
    logic [15:0] mb;
    logic in_en, in_any;
    mb = 16'(a >> 20);
    in_en = 1'b0;
    in_any = 1'b0;
    for (int w = 0; w < NW; w++) begin
      if (mb >= mreg[w] && mb <= mreg[w+NW]) begin
        in_any = 1'b1;
        if (mreg[16][w]) in_en = 1'b1;
      end
    end
    if (mreg[16][9] || s) return 1'b1;
    return !(in_en || (!in_any && mreg[16][8]));
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] mask, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_idx = 5'(idx);
    cfg_wdata = {mask, data};
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < NR) mreg[idx] = (mreg[idx] & ~mask) | (data & mask);
  endtask

  task automatic acc(input string req, input logic [31:0] a, input logic s);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr = a;
    acc_secure = s;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, dec_valid, 1'b1);
    check(req, dec_allow, expect_allow(a, s));
  endtask

  function automatic logic [31:0] mbaddr(input int mb, input logic [19:0] off);
    return (32'(mb) << 20) | 32'(off);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 valid", dec_valid, 1'b0);
    check("R1 allow", dec_allow, 1'b1);
    acc("R1", mbaddr(100, 20'h12345), 1'b0);
    acc("R1", 32'h0000_0000, 1'b0);
    // R9: idle cycle drops valid
    @(negedge clk);
    check("R9 idle", dec_valid, 1'b0);

    // R3: window 0 covers MB 2..5
    wr(0, 16'hFFFF, 16'd2);
    wr(8, 16'hFFFF, 16'd5);
    wr(16, 16'h0001, 16'h0001);
    acc("R3 below", mbaddr(1, 20'hFFFFF), 1'b0);
    check("R3 below", dec_allow, 1'b1);
    acc("R3 start", mbaddr(2, 20'h0), 1'b0);
    check("R3 start", dec_allow, 1'b0);
    acc("R3 end", mbaddr(5, 20'hFFFFF), 1'b0);
    check("R3 end", dec_allow, 1'b0);
    acc("R3 past", mbaddr(6, 20'h0), 1'b0);
    check("R3 past", dec_allow, 1'b1);
    // R6: secure passes inside guarded window
    acc("R6", mbaddr(3, 20'h0), 1'b1);
    check("R6", dec_allow, 1'b1);

    // R4: window 1 start=end=0 enabled
    wr(16, 16'h0002, 16'h0002);
    acc("R4 last", 32'h000F_FFFF, 1'b0);
    check("R4 last", dec_allow, 1'b0);
    acc("R4 next", 32'h0010_0000, 1'b0);
    check("R4 next", dec_allow, 1'b1);

    // R2: mask 0 leaves bit 8 clear; outside memory stays open
    wr(16, 16'h0000, 16'h0100);
    acc("R2 masked", mbaddr(200, 20'h0), 1'b0);
    check("R2 masked", dec_allow, 1'b1);

    // R5: disabling window 1 (masked write) opens MB 0
    wr(16, 16'h0002, 16'h0000);
    acc("R5 disabled", 32'h0000_0040, 1'b0);
    check("R5 disabled", dec_allow, 1'b1);

    // R7: default protection denies outside, disabled window MB 0 stays open
    wr(16, 16'h0100, 16'h0100);
    acc("R7 outside", mbaddr(200, 20'h0), 1'b0);
    check("R7 outside", dec_allow, 1'b0);
    acc("R7 disabled win", 32'h0000_0040, 1'b0);
    check("R7 disabled win", dec_allow, 1'b1);
    acc("R7 secure", mbaddr(200, 20'h0), 1'b1);

    // R10: out-of-range index is ignored (bypass would open everything)
    wr(17, 16'hFFFF, 16'hFFFF);
    wr(31, 16'hFFFF, 16'hFFFF);
    acc("R10", mbaddr(200, 20'h0), 1'b0);
    check("R10", dec_allow, 1'b0);

    // R8: bypass
    wr(16, 16'h0200, 16'h0200);
    acc("R8 window", mbaddr(3, 20'h0), 1'b0);
    check("R8 window", dec_allow, 1'b1);
    acc("R8 outside", mbaddr(900, 20'h0), 1'b0);
    check("R8 outside", dec_allow, 1'b1);
    wr(16, 16'h0200, 16'h0000);

    // Random mix: R2 R3 R5 R7 R9
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        int idx;
        logic [15:0] d;
        idx = $urandom_range(0, 18);
        if (idx < 16) d = {10'($urandom), 6'($urandom)} & 16'h003F;
        else d = 16'($urandom) & 16'h03FF;
        if (idx == 16 && $urandom_range(0, 3) != 0) d[9] = 1'b0;
        wr(idx, 16'($urandom), d);
      end else if ($urandom_range(0, 7) == 0) begin
        acc("R7 random wide", $urandom, 1'($urandom));
      end else begin
        acc("R5 random", mbaddr($urandom_range(0, 63), 20'($urandom)), 1'($urandom));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule